// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

A byte-wide behavioural model of a 128 KB boot-block flash memory with a command-driven interface. A host issues single-byte reads and writes on a 17-bit address bus. Writes either load a command byte or complete a two-step program or erase sequence. Reads return the array, the identifier bytes or the status byte, depending on the current command. Programming can only clear bits. Erase is the only way to set bits back to 1, and it works on whole blocks taken from a fixed table. Two straps pick the table: top-boot or bottom-boot layout, and an optional inversion of address bit 16. The boot block can never be programmed or erased.

Storage is organised as thirty-two 4 KB regions, and every block edge lies on a region edge. Parameter `MEM_AW` sets how many bytes are kept. Each region keeps 2^(MEM_AW-5) bytes, and the twelve in-region address bits are XOR-folded onto that depth. With `MEM_AW` = 17 the full array is kept. Erase, and the blank fill after reset, write one stored byte per clock and hold `busy_o` high while they run. A host holds `req_i` until `busy_o` is low.

Top module: `bbflash_ctrl`

## Requirements
- R1: After reset the command is read-array and status is 0x00. `busy_o` is high from reset until every stored byte has been filled with 0xFF, and `rvalid_o` is low.
- R2: After command 0x90, a read at an odd address returns the device code (0x94 top-boot, 0x95 bottom-boot) and a read at an even address returns 0x89.
- R3: After command 0x70, a read at any address returns the status byte. Writing command 0x50 clears status to 0x00.
- R4: After command 0x40 or 0x10, the next write stores the bitwise AND of its data with the stored byte. The command then becomes 0x70 and status becomes 0x80.
- R5: A program write whose effective address bits 16:13 match the boot block (0xF top-boot, 0x0 bottom-boot) leaves the array unchanged. The command and status still advance as in R4.
- R6: After command 0x20, a write of 0xD0 erases every erasable block that holds the effective address, sets status to 0x80 and switches the command to 0x70.
- R7: After command 0x20, a write of any other value erases nothing, leaves status unchanged and switches the command to 0x70.
- R8: Top-boot blocks are main 0x00000-0x1BFFF, data1 0x1C000-0x1CFFF, data2 0x1D000-0x1DFFF and boot 0x1E000-0x1FFFF. An erase never touches other blocks. An erase aimed at the boot block does nothing and does not raise `busy_o`.
- R9: Bottom-boot blocks are boot 0x00000-0x01FFF, data1 0x03000-0x03FFF, main 0x04000-0x1FFFF and data2 0x04000-0x04FFF. An erase in 0x04000-0x04FFF clears all of main. An erase in 0x02000-0x02FFF or in boot does nothing.
- R10: With `invert_a16_i` high, address bit 16 is flipped before every read and write, including the boot protection and the block lookup.
- R11: An erase of N regions holds `busy_o` high for N*2^(MEM_AW-5) cycles and accepts no access while busy. An accepted read gives `rvalid_o` and its data on the next cycle.
- R12: In any command mode other than 0x90 and 0x70, including 0x50 and 0xB0, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bottom_boot_i | input | 1 | Strap: 1 selects bottom-boot layout, 0 top-boot |
| invert_a16_i | input | 1 | Strap: 1 flips address bit 16 |
| req_i | input | 1 | Access request, held until accepted |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data or command byte |
| busy_o | output | 1 | Fill or erase running; requests stall |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |

## Verification
The hardest case to reach is the bottom-boot overlap, where data2 sits inside main. An erase there must clear all of main while data1, the unmapped gap region and the boot block keep their contents. The stimulus first programs distinct marker bytes into each of those regions, then erases through an address in the overlap and reads every marker back. It also erases through the gap and checks that `busy_o` never rises. The inversion strap gets the same marker method: a program aimed at the boot block through the flipped bit must leave the array unchanged.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
  localparam int ADDR_W = 17;
  localparam int REG_W  = 5;   // 4 KB regions, addr[16:12]
  localparam int N_ERS  = 3;   // erasable blocks: main, data1, data2
  localparam logic [REG_W-1:0] RG_LAST = 5'd31;

  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_ERS   = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_PGM_A = 8'h40;
  localparam logic [7:0] CMD_PGM_B = 8'h10;

  localparam logic [7:0] MFR_CODE  = 8'h89;
  localparam logic [7:0] DEV_TOP   = 8'h94;
  localparam logic [7:0] DEV_BOT   = 8'h95;
  localparam logic [7:0] STAT_RDY  = 8'h80;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef struct packed {
    logic [REG_W-1:0] lo;
    logic [REG_W-1:0] hi;
  } span_t;

  typedef enum logic [1:0] {RSEL_ARRAY, RSEL_IDENT, RSEL_STAT} rsel_e;

  // erasable block spans in 4 KB regions; 0 main, 1 data1, 2 data2
  function automatic span_t ers_span(input int idx, input logic bottom);
    span_t s;
    case (idx)
      0:       s = bottom ? '{lo: 5'd4,  hi: 5'd31} : '{lo: 5'd0,  hi: 5'd27};
      1:       s = bottom ? '{lo: 5'd3,  hi: 5'd3}  : '{lo: 5'd28, hi: 5'd28};
      default: s = bottom ? '{lo: 5'd4,  hi: 5'd4}  : '{lo: 5'd29, hi: 5'd29};
    endcase
    return s;
  endfunction

  // addr[16:13] of the boot block
  function automatic logic [3:0] boot_tag(input logic bottom);
    return bottom ? 4'h0 : 4'hF;
  endfunction
endpackage

// File: rtl/bbf_blk_map.sv
module bbf_blk_map
  import bbf_pkg::*;
(
  input  logic             bottom_i,
  input  logic [REG_W-1:0] region_i,
  output logic             hit_o,
  output span_t            span_o,
  output logic             boot_o
);
  span_t spans [N_ERS];

  for (genvar g = 0; g < N_ERS; g++) begin : g_blk
    assign spans[g] = ers_span(g, bottom_i);
  end

  logic [N_ERS-1:0] hit_c;
  logic [REG_W-1:0] lo_c, hi_c;
  logic             boot_c;

  always_comb begin
    lo_c   = RG_LAST;
    hi_c   = '0;
    boot_c = (region_i[REG_W-1:1] == boot_tag(bottom_i));
    for (int i = 0; i < N_ERS; i++) begin
      hit_c[i] = (region_i >= spans[i].lo) && (region_i <= spans[i].hi);
      if (hit_c[i]) begin
        if (spans[i].lo < lo_c) lo_c = spans[i].lo;
        if (spans[i].hi > hi_c) hi_c = spans[i].hi;
      end
    end
    // R8 R9
    boot_safe_chk: assert (!((|hit_c) && boot_c));
    // R9
    span_cover_chk: assert (!(|hit_c) || ((lo_c <= region_i) && (region_i <= hi_c)));
  end

  assign hit_o  = |hit_c;
  assign span_o = '{lo: lo_c, hi: hi_c};
  assign boot_o = boot_c;
endmodule

// File: rtl/bbf_seq.sv
module bbf_seq
  import bbf_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  span_t            span_i,
  output logic             busy_o,
  output logic [REG_W-1:0] region_o,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic             run_q;
  logic [REG_W-1:0] rg_q, last_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      rg_q   <= '0;
      last_q <= '0;
      off_q  <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      rg_q   <= span_i.lo;
      last_q <= span_i.hi;
      off_q  <= '0;
    end else if (run_q) begin
      if (off_q == OFF_MAX) begin
        off_q <= '0;
        if (rg_q == last_q) run_q <= 1'b0;
        else                rg_q  <= rg_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign busy_o   = run_q;
  assign region_o = rg_q;
  assign off_o    = off_q;

  // R11
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
  // R11
  seq_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (rg_q <= last_q));
endmodule

// File: rtl/bbf_store.sv
module bbf_store #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          and_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= and_i ? (mem[idx_i] & wdata_i) : wdata_i;
    rd_q <= mem[idx_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bbflash_ctrl.sv
module bbflash_ctrl
  import bbf_pkg::*;
#(
  parameter int MEM_AW = 11  // 6..17; 17 keeps every byte
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bottom_boot_i,
  input  logic              invert_a16_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o
);
  localparam int OFF_W = MEM_AW - REG_W;
  localparam int IN_W  = ADDR_W - REG_W;

  logic [7:0]       cmd_q, stat_q;
  logic             init_q, rvalid_q, odd_q;
  rsel_e            rsel_q;

  logic [REG_W-1:0] region;
  logic [OFF_W-1:0] off_c;
  logic             map_hit, map_boot;
  span_t            map_span;

  logic             seq_busy, seq_start;
  logic [REG_W-1:0] seq_rg;
  logic [OFF_W-1:0] seq_off;
  span_t            seq_span;

  logic             acc, wr, rd, ers_mode, pgm_mode;
  logic             st_we, st_and;
  logic [MEM_AW-1:0] st_idx;
  logic [7:0]       st_wd, st_rd;

  // effective address: optional flip of bit 16
  assign region = addr_i[ADDR_W-1:IN_W] ^ {invert_a16_i, {(REG_W-1){1'b0}}};

  // fold in-region offset onto stored depth
  always_comb begin
    off_c = '0;
    for (int i = 0; i < IN_W; i++) off_c[i % OFF_W] = off_c[i % OFF_W] ^ addr_i[i];
  end

  bbf_blk_map u_map (
    .bottom_i (bottom_boot_i),
    .region_i (region),
    .hit_o    (map_hit),
    .span_o   (map_span),
    .boot_o   (map_boot)
  );

  assign busy_o   = seq_busy | ~init_q;
  assign acc      = req_i & ~busy_o;
  assign wr       = acc & we_i;
  assign rd       = acc & ~we_i;
  assign ers_mode = (cmd_q == CMD_ERS);
  assign pgm_mode = (cmd_q == CMD_PGM_A) || (cmd_q == CMD_PGM_B);

  assign seq_start = ~init_q | (wr & ers_mode & (wdata_i == CMD_CONF) & map_hit);
  assign seq_span  = init_q ? map_span : '{lo: '0, hi: RG_LAST};

  bbf_seq #(.OFF_W(OFF_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (seq_start),
    .span_i   (seq_span),
    .busy_o   (seq_busy),
    .region_o (seq_rg),
    .off_o    (seq_off)
  );

  assign st_we  = seq_busy | (wr & pgm_mode & ~map_boot);
  assign st_and = ~seq_busy;
  assign st_idx = seq_busy ? {seq_rg, seq_off} : {region, off_c};
  assign st_wd  = seq_busy ? FILL_BYTE : wdata_i;

  bbf_store #(.AW(MEM_AW)) u_store (
    .clk_i   (clk_i),
    .we_i    (st_we),
    .and_i   (st_and),
    .idx_i   (st_idx),
    .wdata_i (st_wd),
    .rdata_o (st_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= CMD_ARRAY;
      stat_q   <= '0;
      init_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rsel_q   <= RSEL_ARRAY;
      odd_q    <= 1'b0;
    end else begin
      init_q   <= 1'b1;
      rvalid_q <= rd;
      if (rd) begin
        odd_q <= addr_i[0];
        if (cmd_q == CMD_IDENT)     rsel_q <= RSEL_IDENT;
        else if (cmd_q == CMD_STAT) rsel_q <= RSEL_STAT;
        else                        rsel_q <= RSEL_ARRAY;
      end
      if (wr) begin
        if (ers_mode) begin
          if (wdata_i == CMD_CONF) stat_q <= STAT_RDY;
          cmd_q <= CMD_STAT;
        end else if (pgm_mode) begin
          cmd_q  <= CMD_STAT;
          stat_q <= STAT_RDY;
        end else begin
          cmd_q <= wdata_i;
          if (wdata_i == CMD_CLR) stat_q <= '0;
        end
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_IDENT: rdata_o = odd_q ? (bottom_boot_i ? DEV_BOT : DEV_TOP) : MFR_CODE;
      RSEL_STAT:  rdata_o = stat_q;
      default:    rdata_o = st_rd;
    endcase
  end

  assign rvalid_o = rvalid_q;

  // R11
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !busy_o) |=> rvalid_o);
  // R11
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cmd_q) && $stable(stat_q)));
  // R6 R7
  ers_to_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !busy_o && cmd_q == CMD_ERS) |=> (cmd_q == CMD_STAT));
  // R5
  pgm_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we && !seq_busy) |-> !map_boot);
  // R3
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !ers_mode && !pgm_mode && wdata_i == CMD_CLR) |=> (stat_q == 8'h00));
endmodule

// File: tb/sim_bbflash_ctrl.sv
module sim_bbflash_ctrl;
  localparam int MEM_AW       = 11;
  localparam int REGION_BYTES = 2 ** (MEM_AW - 5);

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 51;
  // top-boot, no inversion, array blank at start
  localparam vec_t VECS [NV] = '{
    '{1'b1, 17'h00000, 8'h40, 8'h00, 4'd4},   // R4
    '{1'b1, 17'h00010, 8'hA5, 8'h00, 4'd4},
    '{1'b0, 17'h00010, 8'h00, 8'h80, 4'd3},   // R3 status after program
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd4},
    '{1'b0, 17'h00010, 8'h00, 8'hA5, 4'd4},
    '{1'b1, 17'h00000, 8'h10, 8'h00, 4'd4},   // alt program code
    '{1'b1, 17'h00010, 8'h3C, 8'h00, 4'd4},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd4},
    '{1'b0, 17'h00010, 8'h00, 8'h24, 4'd4},   // A5 & 3C
    '{1'b1, 17'h00000, 8'h90, 8'h00, 4'd2},   // R2
    '{1'b0, 17'h00000, 8'h00, 8'h89, 4'd2},
    '{1'b0, 17'h00001, 8'h00, 8'h94, 4'd2},
    '{1'b0, 17'h1E003, 8'h00, 8'h94, 4'd2},
    '{1'b1, 17'h00000, 8'h70, 8'h00, 4'd3},
    '{1'b0, 17'h1C000, 8'h00, 8'h80, 4'd3},
    '{1'b1, 17'h00000, 8'h50, 8'h00, 4'd12},  // R12 mode 0x50 reads array
    '{1'b0, 17'h00010, 8'h00, 8'h24, 4'd12},
    '{1'b1, 17'h00000, 8'h70, 8'h00, 4'd3},
    '{1'b0, 17'h00005, 8'h00, 8'h00, 4'd3},
    '{1'b1, 17'h1E000, 8'h40, 8'h00, 4'd5},   // R5 boot program
    '{1'b1, 17'h1E004, 8'h00, 8'h00, 4'd5},
    '{1'b0, 17'h1E004, 8'h00, 8'h80, 4'd5},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd5},
    '{1'b0, 17'h1E004, 8'h00, 8'hFF, 4'd5},
    '{1'b1, 17'h1C004, 8'h40, 8'h00, 4'd5},
    '{1'b1, 17'h1C004, 8'h11, 8'h00, 4'd5},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd5},
    '{1'b0, 17'h1C004, 8'h00, 8'h11, 4'd5},
    '{1'b1, 17'h00000, 8'h50, 8'h00, 4'd7},   // R7 cancelled erase
    '{1'b1, 17'h1C000, 8'h20, 8'h00, 4'd7},
    '{1'b1, 17'h1C000, 8'h55, 8'h00, 4'd7},
    '{1'b0, 17'h1C004, 8'h00, 8'h00, 4'd7},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd7},
    '{1'b0, 17'h1C004, 8'h00, 8'h11, 4'd7},
    '{1'b1, 17'h00000, 8'hB0, 8'h00, 4'd12},
    '{1'b0, 17'h1C004, 8'h00, 8'h11, 4'd12},
    '{1'b1, 17'h1D000, 8'h40, 8'h00, 4'd8},   // R8 marker in data2
    '{1'b1, 17'h1D001, 8'h00, 8'h00, 4'd8},
    '{1'b1, 17'h1C000, 8'h20, 8'h00, 4'd6},   // R6 erase data1
    '{1'b1, 17'h1C020, 8'hD0, 8'h00, 4'd6},
    '{1'b0, 17'h1C004, 8'h00, 8'h80, 4'd6},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd6},
    '{1'b0, 17'h1C004, 8'h00, 8'hFF, 4'd6},
    '{1'b0, 17'h00010, 8'h00, 8'h24, 4'd8},
    '{1'b0, 17'h1D001, 8'h00, 8'h00, 4'd8},
    '{1'b1, 17'h1B000, 8'h20, 8'h00, 4'd8},   // erase main
    '{1'b1, 17'h1B000, 8'hD0, 8'h00, 4'd8},
    '{1'b1, 17'h00000, 8'hFF, 8'h00, 4'd8},
    '{1'b0, 17'h00010, 8'h00, 8'hFF, 4'd8},
    '{1'b0, 17'h1D001, 8'h00, 8'h00, 4'd8},
    '{1'b0, 17'h1C004, 8'h00, 8'hFF, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bottom = 1'b0;
  logic        inv = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, rvalid;
  logic [7:0]  rdata;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bbflash_ctrl #(.MEM_AW(MEM_AW)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bottom_boot_i (bottom),
    .invert_a16_i  (inv),
    .req_i         (req),
    .we_i          (we),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .busy_o        (busy),
    .rvalid_o      (rvalid),
    .rdata_o       (rdata)
  );

  task automatic chk(input int rq, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wait_idle();
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input int rq, input logic [16:0] a, input logic [7:0] exp);
    wait_idle();
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    if (!rvalid) begin
      n_fail++;
      $display("FAIL R11: rvalid actual 0 expected 1");
    end
    chk(rq, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic do_reset(input logic b, input logic v);
    rst_n = 1'b0; bottom = b; inv = v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    // R1 reset state
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(1, {15'd0, busy}, 16'd1);
    chk(1, {15'd0, rvalid}, 16'd0);
    rd_chk(1, 17'h00010, 8'hFF);
    rd_chk(1, 17'h1E004, 8'hFF);
    wr(17'h00000, 8'h70);
    rd_chk(1, 17'h00000, 8'h00);
    wr(17'h00000, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else            rd_chk(int'(VECS[i].rq), VECS[i].addr, VECS[i].exp);
    end

    // R11 one-region erase busy length
    wr(17'h1C000, 8'h20);
    wr(17'h1C000, 8'hD0);
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    chk(11, 16'(cnt), 16'(REGION_BYTES));

    // R8 erase aimed at boot does nothing
    wr(17'h00000, 8'h50);
    wr(17'h1E000, 8'h20);
    wr(17'h1E000, 8'hD0);
    chk(8, {15'd0, busy}, 16'd0);
    rd_chk(6, 17'h1E000, 8'h80);

    // bottom-boot variant
    do_reset(1'b1, 1'b0);
    wr(17'h00000, 8'h90);
    rd_chk(2, 17'h00001, 8'h95);
    rd_chk(2, 17'h00002, 8'h89);
    wr(17'h01004, 8'h40);
    wr(17'h01004, 8'h00);
    wr(17'h00000, 8'hFF);
    rd_chk(5, 17'h01004, 8'hFF);
    wr(17'h02004, 8'h40); wr(17'h02004, 8'h12);
    wr(17'h03004, 8'h40); wr(17'h03004, 8'h34);
    wr(17'h04004, 8'h40); wr(17'h04004, 8'h56);
    wr(17'h10004, 8'h40); wr(17'h10004, 8'h78);
    wr(17'h00000, 8'hFF);
    rd_chk(4, 17'h10004, 8'h78);
    // R9 overlap erase clears all of main
    wr(17'h04000, 8'h20);
    wr(17'h04010, 8'hD0);
    wr(17'h00000, 8'hFF);
    rd_chk(9, 17'h04004, 8'hFF);
    rd_chk(9, 17'h10004, 8'hFF);
    rd_chk(9, 17'h03004, 8'h34);
    rd_chk(9, 17'h02004, 8'h12);
    // R9 gap region erase does nothing
    wr(17'h02000, 8'h20);
    wr(17'h02000, 8'hD0);
    chk(9, {15'd0, busy}, 16'd0);
    wr(17'h00000, 8'hFF);
    rd_chk(9, 17'h02004, 8'h12);
    wr(17'h03000, 8'h20);
    wr(17'h03000, 8'hD0);
    wr(17'h00000, 8'hFF);
    rd_chk(9, 17'h03004, 8'hFF);

    // R10 inverted bit 16, top-boot
    do_reset(1'b0, 1'b1);
    wr(17'h1E004, 8'h40);
    wr(17'h1E004, 8'h5A);
    wr(17'h00000, 8'hFF);
    rd_chk(10, 17'h1E004, 8'h5A);
    rd_chk(10, 17'h0E004, 8'hFF);
    wr(17'h0E008, 8'h40);
    wr(17'h0E008, 8'h00);
    wr(17'h00000, 8'hFF);
    rd_chk(10, 17'h0E008, 8'hFF);
    wr(17'h1C000, 8'h20);
    wr(17'h1C000, 8'hD0);
    wr(17'h00000, 8'hFF);
    rd_chk(10, 17'h1E004, 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule